// File: doc/BRIEF.md
# Block Floating-Point Scaling Controller

This block keeps the data of an in-place radix-2 FFT engine inside its word width. During every pass over the sample block, it watches each butterfly result the engine writes back and records whether any real or imaginary part has reached into the two guard bits. When the pass closes, that record becomes the scaling decision for the next pass. Each operand read for the next pass then goes through a combinational arithmetic right shift by one bit, and every shift is counted in a block exponent. The engine reports the exponent next to the transform result.

A transform opens with `xfrm_start`. A chain of passes follows, each framed by a `stage_start` pulse and a `stage_done` pulse.
- Pass 0 is the load pass. The raw input samples are shown on the monitor port, so the input block is checked for growth like any stage.
- Passes 1 to `LOG2_PTS` are the butterfly stages.
- After the last pass, the operand port still applies the last decision, so the result readout comes out scaled.

`scale_mode` picks one of two scaling modes:
- **0, conditional:** shift only after a pass that grew.
- **1, unconditional:** shift after every butterfly stage, for an overall 1/N.

The mode is latched at `xfrm_start`.

Both data interfaces use valid/ready.
- **Monitor port:** a sample is taken in a cycle where `mon_valid` and `mon_ready` are both high. `mon_ready` is high only while a pass is open. The producer must hold its sample until it is taken, and outside a pass the sample is never taken.
- **Operand port:** this port is a combinational pass-through. Valid flows forward, ready flows backward, and the block adds no storage. Back-pressure from the consumer therefore stalls the producer in the same cycle.

Top module: `bfp_scaler`

## Requirements
- R1: After reset, and in the cycle after `xfrm_start`, `blk_exp` is 0, `exp_final` is 0 and `mon_ready` is 0. The operand port then passes data unshifted.
- R2: A monitored sample has grown when bit DATA_W-2 or bit DATA_W-3 differs from the sign bit DATA_W-1, in either the real or the imaginary part. For 16-bit data, 8191 and -8192 have not grown, while 8192 and -8193 have.
- R3: In conditional mode (`scale_mode`=0), a pass in which at least one taken monitor sample grew makes the following pass shift its operands, and `blk_exp` rises by 1. A pass with no growth leaves the next pass unshifted and `blk_exp` unchanged.
- R4: The scaling decision of a pass takes effect in the cycle after `stage_done`. During a pass, the operand shift does not change, whatever growth is seen.
- R5: Pass 0 is the input check. In conditional mode, growth seen on the raw input halves the operands of pass 1 and counts in `blk_exp`.
- R6: In unconditional mode (`scale_mode`=1), pass 0 never causes a shift, and each of passes 1 to LOG2_PTS does. The final `blk_exp` is LOG2_PTS.
- R7: While a shift is active, each operand part leaves as its arithmetic right shift by one: sign extended, with the low bit dropped, so the result rounds toward minus infinity. Otherwise the part leaves unchanged.
- R8: `opd_out_valid` equals `opd_in_valid` and `opd_in_ready` equals `opd_out_ready` in the same cycle, and the data path is combinational.
- R9: `mon_ready` is high only between an accepted `stage_start` and its `stage_done`. Samples offered outside a pass have no effect on any decision.
- R10: `scale_mode` is sampled only at `xfrm_start`. Changing it during a transform has no effect.
- R11: `exp_final` rises in the cycle after the `stage_done` of pass LOG2_PTS and holds until the next `xfrm_start`. While it is high, `stage_start` and monitor samples are ignored and `blk_exp` stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scale_mode | input | 1 | 0 conditional, 1 unconditional; latched at xfrm_start |
| xfrm_start | input | 1 | Pulse: begin a new transform |
| stage_start | input | 1 | Pulse: open the next pass |
| stage_done | input | 1 | Pulse: close the open pass |
| mon_valid | input | 1 | Butterfly result offered for monitoring |
| mon_ready | output | 1 | Monitor accepts samples (a pass is open) |
| mon_re | input | DATA_W | Monitored real part |
| mon_im | input | DATA_W | Monitored imaginary part |
| opd_in_valid | input | 1 | Operand from sample memory valid |
| opd_in_ready | output | 1 | Operand accepted (mirrors opd_out_ready) |
| opd_in_re | input | DATA_W | Operand real part |
| opd_in_im | input | DATA_W | Operand imaginary part |
| opd_out_valid | output | 1 | Scaled operand valid |
| opd_out_ready | input | 1 | Butterfly accepts scaled operand |
| opd_out_re | output | DATA_W | Scaled operand real part |
| opd_out_im | output | DATA_W | Scaled operand imaginary part |
| blk_exp | output | EXP_W | Number of one-bit shifts applied so far |
| exp_final | output | 1 | All passes done; blk_exp is final |

## Verification
Suppose the growth flag is stuck or clears late. The first symptom is a wrong `blk_exp` one cycle after the `stage_done` that closes the affected pass. The operand words of the following pass then come out halved or unhalved by mistake. A shift decision that is applied too early would alter operands inside the very pass that saw the growth, which shows up on the operand port within a cycle. Errors in the mode latch or the pass count appear at the latest when `exp_final` rises, as a final exponent different from the one the per-pass peak-magnitude model predicts.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

  typedef enum logic {
    SCALE_COND   = 1'b0,
    SCALE_UNCOND = 1'b1
  } scale_mode_e;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_GAP   = 2'd1,
    CS_PASS  = 2'd2,
    CS_FINAL = 2'd3
  } ctrl_state_e;

  localparam int unsigned GUARD_BITS = 2;

endpackage

// File: rtl/bfp_growth_detect.sv
module bfp_growth_detect #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic [LANES*DATA_W-1:0] samp,
  output logic                    grew
);
  import bfp_pkg::*;

  localparam int unsigned TOP_W = GUARD_BITS + 1;

  logic [LANES-1:0] lane_grew;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [TOP_W-1:0] top_bits;
    assign top_bits     = samp[g*DATA_W + DATA_W - TOP_W +: TOP_W];
    // R2: sign and both guard bits must agree, else the value entered the guard region
    assign lane_grew[g] = !((top_bits == {TOP_W{1'b0}}) || (top_bits == {TOP_W{1'b1}}));
  end

  assign grew = |lane_grew;

endmodule

// File: rtl/bfp_shifter.sv
module bfp_shifter #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift_en,
  input  logic [LANES*DATA_W-1:0] din,
  output logic [LANES*DATA_W-1:0] dout
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] lane_in;
    logic [DATA_W-1:0] lane_out;

    assign lane_in  = din[g*DATA_W +: DATA_W];
    assign lane_out = shift_en ? {lane_in[DATA_W-1], lane_in[DATA_W-1:1]} : lane_in;
    assign dout[g*DATA_W +: DATA_W] = lane_out;

    // R7: arithmetic shift never changes the sign of an operand
    assert_sign_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lane_out[DATA_W-1] == lane_in[DATA_W-1]);

    // R7: a shifted value never exceeds the input magnitude and differs by half
    assert_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |-> (lane_out[DATA_W-2:0] == lane_in[DATA_W-1:1]));
  end

endmodule

// File: rtl/bfp_stage_ctrl.sv
module bfp_stage_ctrl #(
  parameter int unsigned LOG2_PTS = 5,
  parameter int unsigned EXP_W    = 3,
  parameter int unsigned IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfrm_start,
  input  logic             stage_start,
  input  logic             stage_done,
  input  logic             mode_in,
  input  logic             grow_hit,
  output logic             pass_open,
  output logic             shift_en,
  output logic [EXP_W-1:0] blk_exp,
  output logic             exp_final
);
  import bfp_pkg::*;

  localparam logic [IDX_W-1:0] LAST_PASS = IDX_W'(LOG2_PTS);

  ctrl_state_e      state_q;
  scale_mode_e      mode_q;
  logic [IDX_W-1:0] pass_idx_q;
  logic             flag_q;
  logic             shift_q;
  logic [EXP_W-1:0] exp_q;
  logic             decision;
  logic             closing;

  assign closing  = (state_q == CS_PASS) && stage_done;
  assign decision = (mode_q == SCALE_UNCOND) ? (pass_idx_q != '0) : (flag_q | grow_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CS_IDLE;
      mode_q     <= SCALE_COND;
      pass_idx_q <= '0;
      flag_q     <= 1'b0;
      shift_q    <= 1'b0;
      exp_q      <= '0;
    end else if (xfrm_start) begin
      state_q    <= CS_GAP;
      mode_q     <= scale_mode_e'(mode_in);
      pass_idx_q <= '0;
      flag_q     <= 1'b0;
      shift_q    <= 1'b0;
      exp_q      <= '0;
    end else begin
      unique case (state_q)
        CS_GAP: begin
          if (stage_start) begin
            state_q <= CS_PASS;
            flag_q  <= 1'b0;
          end
        end
        CS_PASS: begin
          if (stage_done) begin
            shift_q    <= decision;
            exp_q      <= exp_q + EXP_W'(decision);
            pass_idx_q <= pass_idx_q + 1'b1;
            state_q    <= (pass_idx_q == LAST_PASS) ? CS_FINAL : CS_GAP;
          end else begin
            flag_q <= flag_q | grow_hit;
          end
        end
        default: ;
      endcase
    end
  end

  assign pass_open = (state_q == CS_PASS);
  assign shift_en  = shift_q;
  assign blk_exp   = exp_q;
  assign exp_final = (state_q == CS_FINAL);

  // R4: shift decision stays fixed for the whole duration of a pass
  assert_shift_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_open && $past(pass_open)) |-> $stable(shift_q));

  // R3: exponent moves by at most one per cycle outside a restart
  assert_exp_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(xfrm_start) |-> ((exp_q == $past(exp_q)) || (exp_q == $past(exp_q) + 1'b1)));

  // R3: growth record starts empty for each pass
  assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_GAP && stage_start && !xfrm_start) |=> !flag_q);

  // R6: load pass in unconditional mode never produces a shift
  assert_uncond_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (closing && pass_idx_q == '0 && mode_q == SCALE_UNCOND && !xfrm_start) |=> !shift_q);

  // R6: unconditional transforms end with exactly LOG2_PTS shifts
  assert_uncond_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_final && mode_q == SCALE_UNCOND) |-> (exp_q == EXP_W'(LOG2_PTS)));

  // R11: final exponent is bounded by one shift per pass
  assert_final_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exp_final |-> (exp_q <= EXP_W'(LOG2_PTS + 1)));

  // R11: once final, the exponent holds until a restart
  assert_final_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_final && !xfrm_start) |=> $stable(exp_q));

endmodule

// File: rtl/bfp_scaler.sv
module bfp_scaler #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LOG2_PTS = 5,
  localparam int unsigned EXP_W   = $clog2(LOG2_PTS + 2),
  localparam int unsigned IDX_W   = $clog2(LOG2_PTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scale_mode,
  input  logic              xfrm_start,
  input  logic              stage_start,
  input  logic              stage_done,
  input  logic              mon_valid,
  output logic              mon_ready,
  input  logic [DATA_W-1:0] mon_re,
  input  logic [DATA_W-1:0] mon_im,
  input  logic              opd_in_valid,
  output logic              opd_in_ready,
  input  logic [DATA_W-1:0] opd_in_re,
  input  logic [DATA_W-1:0] opd_in_im,
  output logic              opd_out_valid,
  input  logic              opd_out_ready,
  output logic [DATA_W-1:0] opd_out_re,
  output logic [DATA_W-1:0] opd_out_im,
  output logic [EXP_W-1:0]  blk_exp,
  output logic              exp_final
);

  localparam int unsigned LANES = 2;

  logic                    pass_open;
  logic                    shift_en;
  logic                    mon_grew;
  logic                    grow_hit;
  logic [LANES*DATA_W-1:0] opd_bus_out;

  bfp_growth_detect #(.DATA_W(DATA_W), .LANES(LANES)) u_detect (
    .samp ({mon_im, mon_re}),
    .grew (mon_grew)
  );

  assign mon_ready = pass_open;
  assign grow_hit  = mon_valid && mon_ready && mon_grew;

  bfp_stage_ctrl #(.LOG2_PTS(LOG2_PTS), .EXP_W(EXP_W), .IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfrm_start  (xfrm_start),
    .stage_start (stage_start),
    .stage_done  (stage_done),
    .mode_in     (scale_mode),
    .grow_hit    (grow_hit),
    .pass_open   (pass_open),
    .shift_en    (shift_en),
    .blk_exp     (blk_exp),
    .exp_final   (exp_final)
  );

  bfp_shifter #(.DATA_W(DATA_W), .LANES(LANES)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      ({opd_in_im, opd_in_re}),
    .dout     (opd_bus_out)
  );

  assign opd_out_re    = opd_bus_out[0 +: DATA_W];
  assign opd_out_im    = opd_bus_out[DATA_W +: DATA_W];
  assign opd_out_valid = opd_in_valid;
  assign opd_in_ready  = opd_out_ready;

  // R9: no monitor sample is accepted once the transform is final
  assert_mon_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exp_final |-> !mon_ready);

  // R8: operand handshake is a straight pass-through
  assert_opd_flow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opd_out_valid == opd_in_valid) && (opd_in_ready == opd_out_ready));

endmodule

// File: tb/bfp_scaler_tb.sv
module bfp_scaler_tb;
  localparam int W   = 16;
  localparam int L   = 5;
  localparam int LIM = 1 << (W - 3);
  localparam int EW  = $clog2(L + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scale_mode = 1'b0, xfrm_start = 1'b0, stage_start = 1'b0, stage_done = 1'b0;
  logic mon_valid = 1'b0, mon_ready;
  logic [W-1:0] mon_re = '0, mon_im = '0;
  logic opd_in_valid = 1'b0, opd_in_ready, opd_out_valid, opd_out_ready = 1'b0;
  logic [W-1:0] opd_in_re = '0, opd_in_im = '0, opd_out_re, opd_out_im;
  logic [EW-1:0] blk_exp;
  logic exp_final;

  bfp_scaler #(.DATA_W(W), .LOG2_PTS(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .scale_mode(scale_mode), .xfrm_start(xfrm_start),
    .stage_start(stage_start), .stage_done(stage_done),
    .mon_valid(mon_valid), .mon_ready(mon_ready), .mon_re(mon_re), .mon_im(mon_im),
    .opd_in_valid(opd_in_valid), .opd_in_ready(opd_in_ready),
    .opd_in_re(opd_in_re), .opd_in_im(opd_in_im),
    .opd_out_valid(opd_out_valid), .opd_out_ready(opd_out_ready),
    .opd_out_re(opd_out_re), .opd_out_im(opd_out_im),
    .blk_exp(blk_exp), .exp_final(exp_final)
  );

  always #4 clk = ~clk;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  m_shift;
  int  m_exp;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference: a sample has grown when its magnitude leaves the non-guard range
  function automatic bit grows(logic [W-1:0] v);
    int s = int'($signed(v));
    return (s >= LIM) || (s < -LIM);
  endfunction

  function automatic logic [W-1:0] small_val();
    int r = int'($urandom_range(2 * LIM - 1));
    return W'(r - LIM);
  endfunction

  function automatic logic [W-1:0] big_val();
    int r = int'($urandom_range(6 * LIM - 1));
    if (r < 3 * LIM) return W'(LIM + r);
    return W'(-(LIM + 1) - (r - 3 * LIM));
  endfunction

  task automatic opd_check(string req);
    logic signed [W-1:0] a, b, ea, eb;
    a = $signed(W'($urandom));
    b = $signed(W'($urandom));
    opd_in_re = a; opd_in_im = b;
    opd_in_valid = 1'($urandom); opd_out_ready = 1'($urandom);
    ea = m_shift ? (a >>> 1) : a;
    eb = m_shift ? (b >>> 1) : b;
    #1;
    chk(opd_out_re == ea, req, $signed(opd_out_re), ea);
    chk(opd_out_im == eb, "R7", $signed(opd_out_im), eb);
    chk(opd_out_valid == opd_in_valid && opd_in_ready == opd_out_ready, "R8",
        {opd_out_valid, opd_in_ready}, {opd_in_valid, opd_out_ready});
  endtask

  task automatic start_xfrm(bit m);
    @(negedge clk); xfrm_start = 1'b1; scale_mode = m;
    @(negedge clk); xfrm_start = 1'b0;
    m_exp = 0; m_shift = 1'b0;
    #1;
    chk(blk_exp == 0, "R1", blk_exp, 0);
    chk(exp_final == 1'b0, "R1", exp_final, 0);
    chk(mon_ready == 1'b0, "R1", mon_ready, 0);
  endtask

  // pat: 0 random, 1 never grows, 2 always grows, 3 threshold values below, 4 threshold values above
  task automatic run_pass(int p, int pat, bit m);
    bit grew = 1'b0;
    string req;
    @(negedge clk);
    mon_valid = 1'b1; mon_re = big_val(); mon_im = big_val();
    scale_mode = 1'($urandom);               // R10: ignored mid-transform
    #1 chk(mon_ready == 1'b0, "R9", mon_ready, 0);
    @(negedge clk); mon_valid = 1'b0; stage_start = 1'b1;
    @(negedge clk); stage_start = 1'b0;
    #1 chk(mon_ready == 1'b1, "R9", mon_ready, 1);
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] re, im;
      bit v;
      @(negedge clk);
      case (pat)
        1: begin v = 1'($urandom); re = small_val(); im = small_val(); end
        2: begin v = 1'b1; re = big_val(); im = small_val(); end
        3: begin v = 1'b1; re = (k[0]) ? W'(LIM - 1) : W'(-LIM); im = (k[0]) ? W'(-LIM) : W'(LIM - 1); end
        4: begin
             v = 1'b1; re = small_val(); im = small_val();
             if (k == 3) im = W'(LIM);
             if (k == 5) re = W'(-LIM - 1);
           end
        default: begin
             v = 1'($urandom);
             re = ($urandom_range(15) == 0) ? big_val() : small_val();
             im = ($urandom_range(15) == 0) ? big_val() : small_val();
           end
      endcase
      mon_valid = v; mon_re = re; mon_im = im;
      if (v) grew |= grows(re) | grows(im);
      opd_check("R4");                        // decision of the previous pass still in force
    end
    @(negedge clk); mon_valid = 1'b0; stage_done = 1'b1;
    @(negedge clk); stage_done = 1'b0;
    m_shift = m ? (p != 0) : grew;
    m_exp  += int'(m_shift);
    if (pat >= 3)      req = "R2";
    else if (p == 0)   req = "R5";
    else if (m)        req = "R6";
    else               req = "R3 R10";
    #1;
    chk(blk_exp == EW'(m_exp), req, blk_exp, m_exp);
    chk(exp_final == (p == L), "R11", exp_final, (p == L));
  endtask

  task automatic run_xfrm(bit m, int pat);
    start_xfrm(m);
    for (int p = 0; p <= L; p++) run_pass(p, pat, m);
    // readout keeps the last decision
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      opd_check("R7");
    end
    // attempts after completion are ignored
    @(negedge clk); stage_start = 1'b1;
    @(negedge clk); stage_start = 1'b0; mon_valid = 1'b1; mon_re = big_val(); mon_im = big_val();
    @(negedge clk); stage_done = 1'b1;
    @(negedge clk); stage_done = 1'b0; mon_valid = 1'b0;
    #1;
    chk(mon_ready == 1'b0, "R11", mon_ready, 0);
    chk(exp_final == 1'b1, "R11", exp_final, 1);
    chk(blk_exp == EW'(m_exp), "R11", blk_exp, m_exp);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog R11 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_exp = 0; m_shift = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(blk_exp == 0, "R1", blk_exp, 0);
    chk(exp_final == 1'b0, "R1", exp_final, 0);
    chk(mon_ready == 1'b0, "R1", mon_ready, 0);
    @(negedge clk); rst_n = 1'b1;
    opd_check("R1");
    // stage pulses before any transform start are ignored
    @(negedge clk); stage_start = 1'b1;
    @(negedge clk); stage_start = 1'b0;
    #1 chk(mon_ready == 1'b0, "R9", mon_ready, 0);

    run_xfrm(1'b0, 1);   // R3: no growth, exponent stays 0
    run_xfrm(1'b0, 2);   // R3 R5: growth every pass
    run_xfrm(1'b1, 1);   // R6: unconditional regardless of data
    run_xfrm(1'b0, 3);   // R2: threshold values that have not grown
    run_xfrm(1'b0, 4);   // R2: threshold values that have grown
    run_xfrm(1'b1, 2);   // R6 R10
    for (int t = 0; t < 20; t++) run_xfrm(1'($urandom_range(3) == 0), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule